// File: doc/BRIEF.md
# Infrared Wake Pattern Matcher

This block stays powered while the host sleeps and listens to an infrared receiver front end that has already recovered the message timing. It receives one cell at a time, each with a valid strobe. It keeps the most recent 88 cells in a history register. At a programmed point it compares that history against a stored pattern under a per-bit mask. When every cared-for bit agrees, it latches a sticky match flag. Sticky flags that are enabled raise the wake output, and only while the block is globally enabled.

The host programs the block through six byte-wide registers: control, status, event enable, index, data port and compare length. Two 11-byte arrays sit behind the index and data registers. One holds compare values and the other holds mask bits. A selector field in the index register picks the array, and each data write advances the byte address by one. For frames coded as Manchester cell pairs, the compare length register sets after how many received cells the comparison fires. A length of zero moves the comparison to the end-of-message strobe instead.

Top module: `irwake_matcher`

## Requirements
- R1: After reset every register reads zero: control, status, event enable, index, data port and compare length. The wake output is low.
- R2: The index register holds a selector in bits 5:4 and a byte address in bits 3:0. Selector 01 picks the compare array and 10 picks the mask array. Each write to the data port stores the byte into the selected array at the current address, provided the address is below 11. It then increments the address by one, whatever the selector. Reading the data port returns the addressed byte of the selected array and leaves the address unchanged. Register offsets are: control 0, status 1, event enable 2, index 3, data 4, compare length 5.
- R3: Compare array byte j bit k sits at history position 8j+k. Position 0 holds the newest cell and position p holds the cell received p cells earlier. A comparison reports a match when the history equals the compare array at every position whose mask bit is 1. Positions with a clear mask bit are ignored.
- R4: With a nonzero compare length N, the comparison runs once, on the N-th cell accepted since the block was enabled or since the last end-of-message strobe. Further cells do not trigger it again until an end-of-message strobe restarts the count.
- R5: With a compare length of zero, the comparison runs when the end-of-message strobe arrives. A cell arriving in the same cycle is included in the history that is compared.
- R6: The status register holds four sticky flags: bit 0 match, bit 1 end of message, bit 2 buffer event and bit 4 repeat code. The buffer and repeat flags are set by their input strobes. Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged.
- R7: Event enable bit 0 gates the match flag, bit 1 the end-of-message flag and bit 2 the buffer flag. The wake output is high when the global enable is set and at least one enabled flag is set. The repeat flag never drives wake.
- R8: Control bit 0 is the global enable. While it is clear, the block ignores cells and all event strobes, holds wake low, and clears the cell history and count.
- R9: When control bit 3 is set, each received cell is inverted before it enters the history.
- R10: Control bits 5:4 hold a protocol code (0, 1 or 2) that reads back unchanged. Control bits 0, 3 and 5:4 read back as written and the other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at reg_addr, combinational |
| cell_valid | input | 1 | A received cell is present this cycle |
| cell_bit | input | 1 | Value of the received cell |
| msg_end | input | 1 | End-of-message strobe from the front end |
| repeat_seen | input | 1 | Repeat-code strobe from the front end |
| buffer_evt | input | 1 | Buffer event strobe from the front end |
| wake | output | 1 | Wake request |

## Verification
The bench replays random cell streams of random length against random masks and flips one cared-for cell in about half of the trials. A design that compared the wrong positions, or that applied the mask the wrong way round, would then report matches on corrupted streams or miss clean ones. A directed Manchester test programs one encoded nibble and sends it oldest data bit first. A reversed bit order, or a swapped cell pair, would fail to match there. Other directed tests check the following:
- a second pass of N cells after a match does not fire again until an end-of-message strobe;
- a zero length defers the comparison to the end-of-message strobe;
- a disabled block ignores all stimulus;
- a repeat flag with every enable set still leaves wake low.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam int NBYTES = 11;
    localparam int CNT_W  = 8;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_EVEN  = 3'd2;
    localparam logic [2:0] A_INDEX = 3'd3;
    localparam logic [2:0] A_DATA  = 3'd4;
    localparam logic [2:0] A_LEN   = 3'd5;

    localparam logic [1:0] SEL_CMP  = 2'b01;
    localparam logic [1:0] SEL_MASK = 2'b10;

    typedef struct packed {
        logic rpt;
        logic bufe;
        logic endm;
        logic match;
    } flags_t;
endpackage

// File: rtl/irw_regs.sv
module irw_regs
    import irw_pkg::*;
#(
    parameter int NB    = NBYTES,
    parameter int LEN_W = CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [7:0]          wdata,
    output logic                ctrl_en,
    output logic                ctrl_inv,
    output logic [1:0]          ctrl_proto,
    output logic [2:0]          evt_en,
    output logic [LEN_W-1:0]    cmp_len,
    output logic [5:0]          index_val,
    output logic [NB*8-1:0]     cmp_flat,
    output logic [NB*8-1:0]     mask_flat,
    output logic [7:0]          port_rdata
);
    localparam int AW = 4;

    typedef struct packed {
        logic                en;
        logic                inv;
        logic [1:0]          proto;
        logic [2:0]          evt;
        logic [LEN_W-1:0]    len;
        logic [1:0]          sel;
        logic [AW-1:0]       ptr;
        logic [NB-1:0][7:0]  cmp;
        logic [NB-1:0][7:0]  msk;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    r_d.en    = wdata[0];
                    r_d.inv   = wdata[3];
                    r_d.proto = wdata[5:4];
                end
                A_EVEN:  r_d.evt = wdata[2:0];
                A_INDEX: begin
                    r_d.sel = wdata[5:4];
                    r_d.ptr = wdata[AW-1:0];
                end
                A_DATA: begin
                    for (int j = 0; j < NB; j++) begin
                        if (r_q.ptr == AW'(j)) begin
                            if (r_q.sel == SEL_CMP)  r_d.cmp[j] = wdata;
                            if (r_q.sel == SEL_MASK) r_d.msk[j] = wdata;
                        end
                    end
                    r_d.ptr = r_q.ptr + AW'(1);
                end
                A_LEN:   r_d.len = wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        port_rdata = 8'h00;
        for (int j = 0; j < NB; j++) begin
            if (r_q.ptr == AW'(j)) begin
                if (r_q.sel == SEL_CMP)  port_rdata = r_q.cmp[j];
                if (r_q.sel == SEL_MASK) port_rdata = r_q.msk[j];
            end
        end
    end

    assign ctrl_en    = r_q.en;
    assign ctrl_inv   = r_q.inv;
    assign ctrl_proto = r_q.proto;
    assign evt_en     = r_q.evt;
    assign cmp_len    = r_q.len;
    assign index_val  = {r_q.sel, r_q.ptr};
    assign cmp_flat   = r_q.cmp;
    assign mask_flat  = r_q.msk;

    assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA) |=> (r_q.ptr == $past(r_q.ptr) + AW'(1)));
endmodule

// File: rtl/irw_history.sv
module irw_history
    import irw_pkg::*;
#(
    parameter int NB    = NBYTES,
    parameter int LEN_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               inv,
    input  logic               cell_valid,
    input  logic               cell_bit,
    input  logic               msg_end,
    input  logic [LEN_W-1:0]   cmp_len,
    output logic [NB*8-1:0]    hist_next,
    output logic               eval
);
    localparam int NBITS = NB * 8;

    typedef struct packed {
        logic [NBITS-1:0] hist;
        logic [LEN_W-1:0] cnt;
    } hist_t;

    hist_t h_d, h_q;
    logic  at_len;
    logic  sat;

    always_comb begin
        h_d    = h_q;
        sat    = (h_q.cnt == '1);
        at_len = ({1'b0, h_q.cnt} + (LEN_W+1)'(1)) == {1'b0, cmp_len};
        eval   = 1'b0;
        if (!en) begin
            h_d = '0;
        end else begin
            if (cell_valid) begin
                h_d.hist = {h_q.hist[NBITS-2:0], cell_bit ^ inv};
                if (!sat) h_d.cnt = h_q.cnt + LEN_W'(1);
            end
            if (cmp_len != '0)
                eval = cell_valid && !sat && at_len;
            else
                eval = msg_end;
            if (msg_end) h_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign hist_next = h_d.hist;

    assert_hist_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (h_q.cnt == '0 && h_q.hist == '0));
endmodule

// File: rtl/irw_compare.sv
module irw_compare #(
    parameter int NBITS = 88
) (
    input  logic [NBITS-1:0] hist,
    input  logic [NBITS-1:0] pattern,
    input  logic [NBITS-1:0] care,
    output logic             equal
);
    logic [NBITS-1:0] diff;

    always_comb begin
        diff  = (hist ^ pattern) & care;
        equal = (diff == '0);
    end

    always_comb begin
        if (care == '0) assert_dontcare_R3: assert (equal);
    end
endmodule

// File: rtl/irwake_matcher.sv
module irwake_matcher
    import irw_pkg::*;
#(
    parameter int NB    = NBYTES,
    parameter int LEN_W = CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cell_valid,
    input  logic       cell_bit,
    input  logic       msg_end,
    input  logic       repeat_seen,
    input  logic       buffer_evt,
    output logic       wake
);
    localparam int NBITS = NB * 8;

    logic             ctrl_en, ctrl_inv;
    logic [1:0]       ctrl_proto;
    logic [2:0]       evt_en;
    logic [LEN_W-1:0] cmp_len;
    logic [5:0]       index_val;
    logic [NBITS-1:0] cmp_flat, mask_flat, hist_next;
    logic [7:0]       port_rdata;
    logic             eval, equal;

    irw_regs #(.NB(NB), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .ctrl_en(ctrl_en), .ctrl_inv(ctrl_inv), .ctrl_proto(ctrl_proto),
        .evt_en(evt_en), .cmp_len(cmp_len), .index_val(index_val),
        .cmp_flat(cmp_flat), .mask_flat(mask_flat), .port_rdata(port_rdata)
    );

    irw_history #(.NB(NB), .LEN_W(LEN_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .inv(ctrl_inv),
        .cell_valid(cell_valid), .cell_bit(cell_bit), .msg_end(msg_end),
        .cmp_len(cmp_len), .hist_next(hist_next), .eval(eval)
    );

    irw_compare #(.NBITS(NBITS)) u_cmp (
        .hist(hist_next), .pattern(cmp_flat), .care(mask_flat), .equal(equal)
    );

    flags_t st_d, st_q;
    logic [7:0] clr;

    always_comb begin
        clr  = (reg_wr && reg_addr == A_STAT) ? reg_wdata : 8'h00;
        st_d.match = (st_q.match & ~clr[0]) | (ctrl_en & eval & equal);
        st_d.endm  = (st_q.endm  & ~clr[1]) | (ctrl_en & msg_end);
        st_d.bufe  = (st_q.bufe  & ~clr[2]) | (ctrl_en & buffer_evt);
        st_d.rpt   = (st_q.rpt   & ~clr[4]) | (ctrl_en & repeat_seen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake = ctrl_en & |({st_q.bufe, st_q.endm, st_q.match} & evt_en);

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {2'b00, ctrl_proto, ctrl_inv, 2'b00, ctrl_en};
            A_STAT:  reg_rdata = {3'b000, st_q.rpt, 1'b0, st_q.bufe, st_q.endm, st_q.match};
            A_EVEN:  reg_rdata = {5'b00000, evt_en};
            A_INDEX: reg_rdata = {2'b00, index_val};
            A_DATA:  reg_rdata = port_rdata;
            A_LEN:   reg_rdata = 8'(cmp_len);
            default: reg_rdata = 8'h00;
        endcase
    end

    assert_wake_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !wake);
    assert_match_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.match && !(reg_wr && reg_addr == A_STAT && reg_wdata[0])) |=> st_q.match);
    assert_rpt_nowake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_en == 3'b000) |-> !wake);
endmodule

// File: tb/tb_irwake_matcher.sv
module tb_irwake_matcher;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, cell_valid = 0, cell_bit = 0, msg_end = 0, repeat_seen = 0, buffer_evt = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic wake;

    irwake_matcher dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cell_valid(cell_valid), .cell_bit(cell_bit), .msg_end(msg_end),
        .repeat_seen(repeat_seen), .buffer_evt(buffer_evt), .wake(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of the requirements
    logic [87:0] mh, bc, bm;
    int   mcnt, mlen;
    logic men, minv;
    logic [2:0] mevt;
    logic [7:0] mstat;

    function automatic logic exp_match(logic [87:0] h, logic [87:0] c, logic [87:0] m);
        return ((h ^ c) & m) == 88'd0;
    endfunction

    function automatic logic [7:0] manch(logic [3:0] v);
        logic [7:0] r = 0;
        for (int i = 0; i < 4; i++) r |= (v[i] ? 8'h2 : 8'h1) << (2*i);
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
        if (a == 3'd1) mstat = mstat & ~d;
        if (a == 3'd0) begin
            men = d[0]; minv = d[3];
            if (!d[0]) begin mh = 0; mcnt = 0; end
        end
        if (a == 3'd2) mevt = d[2:0];
        if (a == 3'd5) mlen = d;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic send(logic b);
        if (men) begin
            mh = {mh[86:0], b ^ minv};
            if (mlen != 0 && mcnt != 255 && mcnt + 1 == mlen && exp_match(mh, bc, bm)) mstat[0] = 1;
            if (mcnt != 255) mcnt++;
        end
        @(negedge clk); cell_valid = 1; cell_bit = b;
        @(negedge clk); cell_valid = 0;
    endtask

    task automatic end_msg();
        if (men) begin
            mstat[1] = 1;
            if (mlen == 0 && exp_match(mh, bc, bm)) mstat[0] = 1;
            mcnt = 0;
        end
        @(negedge clk); msg_end = 1;
        @(negedge clk); msg_end = 0;
    endtask

    task automatic prog(logic [87:0] c, logic [87:0] m);
        bc = c; bm = m;
        wr(3'd3, 8'h10);
        for (int j = 0; j < 11; j++) wr(3'd4, c[8*j +: 8]);
        wr(3'd3, 8'h20);
        for (int j = 0; j < 11; j++) wr(3'd4, m[8*j +: 8]);
    endtask

    task automatic check_state(string req);
        logic [7:0] s;
        rd(3'd1, s);
        check(req, s, mstat);
        check(req, wake, men & |(mstat[2:0] & mevt));
    endtask

    task automatic restart(logic inv);
        wr(3'd0, 8'h00);
        wr(3'd0, {4'h0, inv, 3'b001});
        wr(3'd1, 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        mh = 0; bc = 0; bm = 0; mcnt = 0; mlen = 0; men = 0; minv = 0; mevt = 0; mstat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1 reg reset", d, 0);
        end
        check("R1 wake reset", wake, 0);

        // R2 array access and auto-increment
        begin
            logic [87:0] rc, rm;
            for (int j = 0; j < 11; j++) begin rc[8*j +: 8] = 8'($urandom); rm[8*j +: 8] = 8'($urandom); end
            prog(rc, rm);
            rd(3'd3, d);
            check("R2 index after fill", d, 8'h2B);
            wr(3'd3, 8'h13);
            rd(3'd4, d); check("R2 compare readback", d, rc[24 +: 8]);
            rd(3'd4, d); check("R2 read no increment", d, rc[24 +: 8]);
            wr(3'd3, 8'h2A);
            rd(3'd4, d); check("R2 mask readback", d, rm[80 +: 8]);
            wr(3'd4, 8'h5A);
            rd(3'd3, d); check("R2 index step", d, 8'h2B);
            wr(3'd3, 8'h2A);
            rd(3'd4, d); check("R2 mask write", d, 8'h5A);
            bm[80 +: 8] = 8'h5A;
            wr(3'd3, 8'h05);
            wr(3'd4, 8'hEE);
            wr(3'd3, 8'h15);
            rd(3'd4, d); check("R2 selector 00 ignored", d, rc[40 +: 8]);
        end

        // R10 control readback
        wr(3'd0, 8'hFF);
        rd(3'd0, d); check("R10 ctrl readback", d, 8'h39);
        wr(3'd0, 8'h20);
        rd(3'd0, d); check("R10 protocol field", d, 8'h20);

        // R3 R4 random masked matches
        for (int t = 0; t < 24; t++) begin
            int len, p;
            logic [87:0] h, m;
            logic cells [88];
            logic inv;
            inv = 1'($urandom);
            case ($urandom % 4)
                0: len = 44; 1: len = 60; 2: len = 76; default: len = 1 + $urandom % 88;
            endcase
            h = 0;
            for (int i = 0; i < len; i++) begin cells[i] = 1'($urandom); h = {h[86:0], cells[i]}; end
            for (int j = 0; j < 11; j++) m[8*j +: 8] = 8'($urandom);
            m = m & ((88'd1 << len) - 88'd1);
            prog(h, m);
            wr(3'd5, 8'(len));
            wr(3'd2, 3'($urandom));
            restart(inv);
            if (($urandom % 2) == 1 && m != 0) begin
                do p = $urandom % len; while (!m[p]);
                cells[len-1-p] = ~cells[len-1-p];
            end
            for (int i = 0; i < len; i++) send(cells[i] ^ inv);
            check_state("R3 random masked compare");
        end

        // R3 Manchester nibble, oldest data bit first
        prog({80'd0, manch(4'hB)}, {80'd0, 8'hFF});
        wr(3'd5, 8'd8); wr(3'd2, 3'b001);
        restart(0);
        for (int i = 3; i >= 0; i--) begin send(4'hB >> i & 1); send(~(4'hB >> i & 1)); end
        check("R3 manchester match", mstat[0], 1);
        check_state("R3 manchester hit");
        restart(0);
        for (int i = 3; i >= 0; i--) begin send(4'hA >> i & 1); send(~(4'hA >> i & 1)); end
        check("R3 manchester miss", mstat[0], 0);
        check_state("R3 manchester miss");

        // R4 one evaluation per count
        prog(88'd0, 88'd0);
        wr(3'd5, 8'd4);
        restart(0);
        repeat (4) send(1);
        check_state("R4 fires at length");
        wr(3'd1, 8'h01);
        repeat (4) send(0);
        check_state("R4 no second evaluation");
        end_msg();
        wr(3'd1, 8'h02);
        repeat (3) send(0);
        check_state("R4 not before length");
        send(0);
        check_state("R4 count restarts after end");

        // R5 length zero evaluates at end of message
        prog(88'h3, 88'h3);
        wr(3'd5, 8'd0);
        restart(0);
        repeat (2) send(1);
        check_state("R5 no eval on cells");
        end_msg();
        check("R5 match at end", mstat[0], 1);
        check_state("R5 eval at end");
        restart(0);
        send(1);
        @(negedge clk); cell_valid = 1; cell_bit = 1; msg_end = 1;
        mh = {mh[86:0], 1'b1}; mstat[1] = 1; if (exp_match(mh, bc, bm)) mstat[0] = 1; mcnt = 0;
        @(negedge clk); cell_valid = 0; msg_end = 0;
        check_state("R5 same-cycle cell included");

        // R6 R7 sticky flags and gating
        restart(0);
        wr(3'd2, 3'b111);
        @(negedge clk); repeat_seen = 1; mstat[4] = 1;
        @(negedge clk); repeat_seen = 0;
        check_state("R7 repeat does not wake");
        check("R7 wake low on repeat", wake, 0);
        @(negedge clk); buffer_evt = 1; mstat[2] = 1;
        @(negedge clk); buffer_evt = 0;
        wr(3'd2, 3'b100);
        check_state("R7 buffer wakes");
        check("R7 buffer wake", wake, 1);
        wr(3'd2, 3'b011);
        check_state("R7 buffer gated off");
        wr(3'd1, 8'h10);
        check_state("R6 clear repeat only");
        wr(3'd1, 8'h04);
        check_state("R6 clear buffer");

        // R8 disabled block ignores input
        wr(3'd0, 8'h00);
        wr(3'd2, 3'b111);
        repeat (4) send(1);
        end_msg();
        @(negedge clk); buffer_evt = 1; repeat_seen = 1;
        @(negedge clk); buffer_evt = 0; repeat_seen = 0;
        check_state("R8 disabled ignores");
        check("R8 wake low", wake, 0);

        // R9 invert
        prog(88'hF, 88'hF);
        wr(3'd5, 8'd4);
        restart(1);
        repeat (4) send(0);
        check("R9 inverted match", mstat[0], 1);
        check_state("R9 invert");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule